// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block holds the time of day as six 8421 BCD digits: seconds, minutes and hours, each with a ones digit and a tens digit. A one-cycle enable tick arrives once per second from a prescaler outside the block. Each tick advances the seconds stage. Seconds and minutes count modulo 60 and hours count modulo 24. When a stage wraps on a genuine time carry, it passes one advance to the stage above it. All digits share one clock and are updated through synchronous enables. No stage is clocked by a ripple clock.

Two hand-set inputs let a user step the minutes or the hours. Each press is a single-cycle pulse from a debouncer outside the block. The pulse is OR-merged with the carry entering that stage, so a press acts as one extra advance of that stage only. A stepped stage that wraps does not carry into the stage above it. A one-cycle flag marks each hour boundary, which is the moment minutes and seconds together roll over to 00:00.

Top module: `tod_counter`

## Requirements
- R1: While `rst` is high at a clock edge, all six digits go to zero (00:00:00) and `hour_flag` goes low after that edge.
- R2: Every digit is 8421 BCD. The seconds ones digit counts 0..9 and the seconds tens digit counts 0..5. A `tick` sampled at an edge adds one second, and the digits show the new value right after that edge.
- R3: A tick at 59 seconds sets the seconds to 00 and advances the minutes by one at the same edge. The tens digit advances only when the ones digit leaves 9, never when it reaches 8.
- R4: Minutes count 00..59 like seconds. When a tick arrives at mm:ss = 59:59, the minutes go to 00 and the hours advance by one at the same edge.
- R5: Hours count 00..23. Ones digit 9 carries into the tens digit (09 to 10, 19 to 20), and 23 goes to 00 on the next advance.
- R6: A one-cycle `min_step` pulse advances the minutes by one. A one-cycle `hr_step` pulse advances the hours by one. Neither pulse changes the seconds.
- R7: A step pulse that wraps its own stage (minutes 59 to 00, or hours 23 to 00) changes no other stage.
- R8: When a step pulse and a real carry reach the same stage in the same cycle, that stage advances by exactly one.
- R9: `hour_flag` is high for exactly the one cycle after the edge at which minutes and seconds wrap together from 59:59 on a tick. A step-caused wrap does not raise it.
- R10: In a cycle with no tick and no step pulse, all digits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to 00:00:00 |
| tick | input | 1 | One-cycle pulse, once per second |
| min_step | input | 1 | One-cycle hand-set pulse for the minutes |
| hr_step | input | 1 | One-cycle hand-set pulse for the hours |
| sec_ones | output | 4 | Seconds, ones digit (BCD) |
| sec_tens | output | 4 | Seconds, tens digit (BCD) |
| min_ones | output | 4 | Minutes, ones digit (BCD) |
| min_tens | output | 4 | Minutes, tens digit (BCD) |
| hr_ones | output | 4 | Hours, ones digit (BCD) |
| hr_tens | output | 4 | Hours, tens digit (BCD) |
| hour_flag | output | 1 | One-cycle mark at each hour boundary |

## Verification
The chain is driven in several ways:
- Sparse ticks separate per-digit BCD stepping from cascade errors.
- An unbroken tick-per-cycle run covers whole minutes and an hour boundary, which exposes any carry that fires at the wrong digit value.
- Bursts of step pulses carry the hours through 09, 19 and 23, and the minutes through 59, with no ticks present. This shows whether a stepped wrap leaks into the next stage.
- A step pulse placed in the same cycle as a genuine 59-second carry tells a single advance from a double one.
- An idle stretch and a reset in the middle of a run confirm that the digits hold and that reset clears them.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned NSTAGES = 3;
  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef struct packed {
    bcd_t tens;
    bcd_t ones;
  } bcd_pair_t;
endpackage

// File: rtl/tod_bcd_digit.sv
module tod_bcd_digit
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wrap,
  output bcd_t q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (en)
      q <= wrap ? bcd_t'(0) : q + bcd_t'(1);
  end
endmodule

// File: rtl/tod_stage.sv
module tod_stage
  import tod_pkg::*;
#(
  parameter int unsigned MODULUS = 60
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      adv,
  output bcd_pair_t val,
  output logic      at_top
);
  localparam bcd_t TOP_T  = bcd_t'((MODULUS - 1) / 10);
  localparam bcd_t TOP_O  = bcd_t'((MODULUS - 1) % 10);
  localparam bcd_t NINE   = bcd_t'(9);

  logic ones_last;
  logic ones_wrap;
  logic tens_en;

  assign at_top    = (val.tens == TOP_T) && (val.ones == TOP_O);
  assign ones_last = (val.ones == NINE);
  assign ones_wrap = ones_last || at_top;
  assign tens_en   = adv && ones_wrap;

  tod_bcd_digit u_ones (
    .clk  (clk),
    .rst  (rst),
    .en   (adv),
    .wrap (ones_wrap),
    .q    (val.ones)
  );

  tod_bcd_digit u_tens (
    .clk  (clk),
    .rst  (rst),
    .en   (tens_en),
    .wrap (at_top),
    .q    (val.tens)
  );
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned SEC_MOD = 60,
  parameter int unsigned MIN_MOD = 60,
  parameter int unsigned HR_MOD  = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       min_step,
  input  logic       hr_step,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] hr_tens,
  output logic       hour_flag
);
  localparam int unsigned LAST = NSTAGES - 1;

  bcd_pair_t          val   [NSTAGES];
  logic [NSTAGES-1:0] top_hit;
  logic [NSTAGES-1:0] real_in;
  logic [NSTAGES-1:0] adv;
  logic [NSTAGES-1:0] step_vec;

  assign step_vec = {hr_step, min_step, 1'b0};

  // Genuine carries ripple only through real time; step pulses join per stage.
  always_comb begin
    real_in[0] = tick;
    for (int i = 1; i < NSTAGES; i++)
      real_in[i] = real_in[i-1] & top_hit[i-1];
    adv = real_in | step_vec;
  end

  for (genvar g = 0; g < NSTAGES; g++) begin : g_stage
    localparam int unsigned MODV = (g == 0) ? SEC_MOD : ((g == 1) ? MIN_MOD : HR_MOD);
    tod_stage #(.MODULUS(MODV)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .adv    (adv[g]),
      .val    (val[g]),
      .at_top (top_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      hour_flag <= 1'b0;
    else
      hour_flag <= real_in[LAST];
  end

  assign sec_ones = val[0].ones;
  assign sec_tens = val[0].tens;
  assign min_ones = val[1].ones;
  assign min_tens = val[1].tens;
  assign hr_ones  = val[2].ones;
  assign hr_tens  = val[2].tens;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       min_step,
  input logic       hr_step,
  input logic [3:0] sec_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [3:0] min_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] hr_tens,
  input logic       hour_flag
);
  logic s59, m59, h23, all_zero_ms;
  assign s59 = (sec_tens == 4'd5) && (sec_ones == 4'd9);
  assign m59 = (min_tens == 4'd5) && (min_ones == 4'd9);
  assign h23 = (hr_tens == 4'd2) && (hr_ones == 4'd3);
  assign all_zero_ms = (sec_tens == 4'd0) && (sec_ones == 4'd0)
                    && (min_tens == 4'd0) && (min_ones == 4'd0);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (all_zero_ms && hr_tens == 4'd0 && hr_ones == 4'd0 && !hour_flag));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && s59) |=> (sec_tens == 4'd0 && sec_ones == 4'd0));

  p_sec_digit_range_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (sec_ones <= 4'd9 && sec_tens <= 4'd5));

  p_hr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (h23 && hr_step) |=> (hr_tens == 4'd0 && hr_ones == 4'd0));

  p_step_no_ripple_r7: assert property (@(posedge clk) disable iff (rst)
    (min_step && m59 && !(tick && s59) && !hr_step) |=>
      ($stable(hr_ones) && $stable(hr_tens)));

  p_flag_at_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    hour_flag |-> all_zero_ms);

  p_flag_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && s59 && m59) |=> hour_flag);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !min_step && !hr_step) |=>
      ($stable(sec_ones) && $stable(sec_tens) && $stable(min_ones) &&
       $stable(min_tens) && $stable(hr_ones) && $stable(hr_tens)));
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .min_step  (min_step),
  .hr_step   (hr_step),
  .sec_ones  (sec_ones),
  .sec_tens  (sec_tens),
  .min_ones  (min_ones),
  .min_tens  (min_tens),
  .hr_ones   (hr_ones),
  .hr_tens   (hr_tens),
  .hour_flag (hour_flag)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic min_step = 1'b0;
  logic hr_step = 1'b0;
  logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
  logic hour_flag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // behavioural reference time
  int ms = 0, mm = 0, mh = 0;
  bit mflag = 0;

  always #4 clk = ~clk;

  tod_counter u0 (
    .clk(clk), .rst(rst), .tick(tick), .min_step(min_step), .hr_step(hr_step),
    .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
    .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens),
    .hour_flag(hour_flag)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ms = 0; mm = 0; mh = 0; mflag = 0;
    end else begin
      bit sec_roll, min_roll;
      sec_roll = tick && (ms == 59);
      min_roll = sec_roll && (mm == 59);
      if (tick) ms = (ms + 1) % 60;
      if (sec_roll || min_step) mm = (mm + 1) % 60;
      if (min_roll || hr_step) mh = (mh + 1) % 24;
      mflag = min_roll;
    end
  end

  task automatic compare(input string req);
    int got_s, got_m, got_h;
    got_s = sec_tens * 10 + sec_ones;
    got_m = min_tens * 10 + min_ones;
    got_h = hr_tens * 10 + hr_ones;
    checks++;
    if (sec_ones > 9 || min_ones > 9 || hr_ones > 9 ||
        got_s != ms || got_m != mm || got_h != mh || hour_flag != mflag) begin
      fails++;
      $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d flag %0b, expected %02d:%02d:%02d flag %0b",
               req, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones, hour_flag,
               mh, mm, ms, mflag);
    end
  endtask

  task automatic cyc(input bit t, input bit m, input bit h, input string req);
    tick = t; min_step = m; hr_step = h;
    @(posedge clk);
    @(negedge clk);
    tick = 0; min_step = 0; hr_step = 0;
    compare(req);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    compare("R1 reset state");
    rst = 0;

    // R2: sparse ticks, one every third cycle
    for (int i = 0; i < 75; i++) begin
      cyc(1, 0, 0, "R2 tick count");
      cyc(0, 0, 0, "R10 hold");
      cyc(0, 0, 0, "R10 hold");
    end
    // R3: continuous ticks through several minutes
    for (int i = 0; i < 250; i++) cyc(1, 0, 0, "R3 seconds wrap");
    // R6: minute steps alone
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 0, "R6 minute step");
      cyc(0, 0, 0, "R10 hold");
    end
    // R5/R6: hour steps through 09, 19, 23
    for (int i = 0; i < 26; i++) cyc(0, 0, 1, "R5 hour step sequence");
    // R7: bring minutes to 59 by steps, then step past with seconds not 59
    while (mm != 59) cyc(0, 1, 0, "R6 minute step");
    if (ms == 59) cyc(1, 0, 0, "R2 tick");
    cyc(0, 1, 0, "R7 minute step wrap no ripple");
    if (hour_flag !== 1'b0) begin
      fails++; $display("FAIL R9: flag %0b after step wrap, expected 0", hour_flag);
    end
    checks++;
    // R7: hours 23 -> 00 by step
    while (mh != 23) cyc(0, 0, 1, "R5 hour step");
    cyc(0, 0, 1, "R7 hour step wrap no ripple");
    // R4/R9: go to 22:59:xx and tick through the hour
    while (mh != 22) cyc(0, 0, 1, "R6 hour step");
    while (mm != 59) cyc(0, 1, 0, "R6 minute step");
    while (ms != 59) cyc(1, 0, 0, "R2 tick");
    cyc(1, 0, 0, "R4 R9 hour boundary");
    cyc(0, 0, 0, "R9 flag drops");
    // R5 wrap through carry: to 23:59:59 then tick
    cyc(0, 0, 0, "R10 hold");
    while (mm != 59) cyc(0, 1, 0, "R6 minute step");
    while (ms != 59) cyc(1, 0, 0, "R2 tick");
    cyc(1, 0, 0, "R5 day wrap via carry");
    // R8: step coinciding with real carry into minutes
    while (ms != 59) cyc(1, 0, 0, "R2 tick");
    cyc(1, 1, 0, "R8 minute step with carry");
    // R8: hour step with real carry into hours
    while (mm != 59) cyc(0, 1, 0, "R6 minute step");
    while (ms != 59) cyc(1, 0, 0, "R2 tick");
    cyc(1, 0, 1, "R8 hour step with carry");
    // R4: unbroken run over more than an hour
    for (int i = 0; i < 3700; i++) cyc(1, 0, 0, "R4 long run");
    // R10 idle
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, "R10 idle hold");
    // R1 mid-run reset
    rst = 1;
    cyc(1, 1, 1, "R1 reset mid-run");
    rst = 0;
    cyc(0, 0, 0, "R1 after reset");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got %0d cycles, expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule